// File: doc/BRIEF.md
# Event-to-Histogram Pixel Accumulator

This block turns a stream of address events from a 128 by 128 event camera into a histogram. The histogram is the input vector of a neural network that computes in step with a MAC enable. Each event names a pixel column, a pixel row and a polarity bit (1 when the light got brighter). The coordinates are coarsened by a configurable right shift, and the polarity is either kept as a separate bin or merged. The result selects one of at most 256 saturating 8-bit counters.

Counting happens only while the MAC enable is low. While it is high the counters hold still, so the network reads a stable histogram through a one-cycle read port. Events that arrive during the high phase are parked in a four-entry queue and counted once the phase falls. Events that find the queue full are lost and tallied. Counts keep growing over successive MAC phases. Only a window-start pulse clears them, and that pulse marks the start of a new recognition window.

Top module: `evhist_accum`

## Requirements
- R1: The bin index is {pol, y >> Y_SHIFT, x >> X_SHIFT}, with the polarity as the most significant bit when KEEP_POL is 1 and left out when it is 0. With the defaults (shift 4, polarity kept) there are 128 bins, and x=5, y=3, pol=1 maps to bin 64.
- R2: With the MAC enable low and the queue empty, an event presented on a clock edge is counted at that same edge.
- R3: While the MAC enable is high, no counter changes, whatever events arrive.
- R4: Counts accumulate across any number of MAC high/low phases and are never cleared by the phase change.
- R5: A counter that holds 255 stays at 255 when further events hit it.
- R6: A window-start pulse clears every counter, empties the queue and zeroes the drop count in one cycle. An event presented in the same cycle is discarded.
- R7: Up to four events that arrive during the high phase are queued. Once the enable is low, one queued event per cycle is counted, while new events keep being accepted.
- R8: An event that arrives while the queue is full, with no pop in the same cycle, is dropped. The drop count output then rises by one and saturates at its maximum.
- R9: The count of the bin on rd_idx appears on rd_cnt one clock edge later.
- R10: After reset all counters, the queue and the drop count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | An event is present this cycle |
| ev_x | input | 7 | Pixel column of the event |
| ev_y | input | 7 | Pixel row of the event |
| ev_pol | input | 1 | Polarity, 1 for rising intensity |
| mac_en | input | 1 | MAC phase; high freezes the counters |
| win_start | input | 1 | Clears the histogram for a new window |
| rd_idx | input | IDX_W (7) | Bin to read |
| rd_cnt | output | CNT_W (8) | Count of the bin addressed one cycle earlier |
| drop_cnt | output | DROP_W (8) | Events lost to a full queue in this window |

## Verification
Two pairs of functions can land in the same cycle. The first is a window-start pulse together with a fresh event. The bench raises both on one edge, then reads the target bin and the drop count and expects them to be zero. The second is a queue pop together with a new arrival, right after the enable falls with events parked. Here the bench keeps presenting events while the queue drains and expects the final count to equal every accepted event, none lost and none counted twice.

// File: rtl/evhist_pkg.sv
package evhist_pkg;
    // Fixed sensor geometry: 128 x 128 pixels.
    localparam int SENS_X_W = 7;
    localparam int SENS_Y_W = 7;

    // Queue operation chosen for one cycle.
    typedef enum logic [1:0] {
        Q_IDLE,
        Q_PUSH,
        Q_POP,
        Q_BOTH
    } q_op_e;
endpackage

// File: rtl/evhist_bin_map.sv
module evhist_bin_map
    import evhist_pkg::*;
#(
    parameter int X_SHIFT  = 4,
    parameter int Y_SHIFT  = 4,
    parameter int KEEP_POL = 1,
    localparam int XB      = SENS_X_W - X_SHIFT,
    localparam int YB      = SENS_Y_W - Y_SHIFT,
    localparam int IDX_W   = XB + YB + KEEP_POL
) (
    input  logic [SENS_X_W-1:0] x,
    input  logic [SENS_Y_W-1:0] y,
    input  logic                pol,
    output logic [IDX_W-1:0]    idx
);
    generate
        if (KEEP_POL != 0) begin : g_pol
            assign idx = {pol, y[SENS_Y_W-1:Y_SHIFT], x[SENS_X_W-1:X_SHIFT]};
        end else begin : g_merge
            logic unused_pol;
            assign unused_pol = pol;
            assign idx = {y[SENS_Y_W-1:Y_SHIFT], x[SENS_X_W-1:X_SHIFT]};
        end
        if (X_SHIFT > 0) begin : g_xlow
            logic unused_x;
            assign unused_x = ^x[X_SHIFT-1:0];
        end
        if (Y_SHIFT > 0) begin : g_ylow
            logic unused_y;
            assign unused_y = ^y[Y_SHIFT-1:0];
        end
    endgenerate
endmodule

// File: rtl/evhist_evq.sv
module evhist_evq
    import evhist_pkg::*;
#(
    parameter int W      = 7,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } q_state_t;

    q_state_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] mem_d [DEPTH];
    q_op_e        op;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign head  = mem_q[st_q.rd];

    always_comb begin
        op = q_op_e'({pop && !empty, push && (!full || pop)});
        st_d  = st_q;
        mem_d = mem_q;
        if (flush) begin
            st_d = '0;
        end else begin
            unique case (op)
                Q_PUSH: begin
                    mem_d[st_q.wr] = push_data;
                    st_d.wr  = nxt(st_q.wr);
                    st_d.cnt = st_q.cnt + 1'b1;
                end
                Q_POP: begin
                    st_d.rd  = nxt(st_q.rd);
                    st_d.cnt = st_q.cnt - 1'b1;
                end
                Q_BOTH: begin
                    mem_d[st_q.wr] = push_data;
                    st_d.wr = nxt(st_q.wr);
                    st_d.rd = nxt(st_q.rd);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            st_q  <= st_d;
            mem_q <= mem_d;
        end
    end

    // R7: occupancy never exceeds the queue depth
    a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/evhist_counters.sv
module evhist_counters #(
    parameter int IDX_W  = 7,
    parameter int CNT_W  = 8,
    localparam int NBINS = 1 << IDX_W,
    localparam logic [CNT_W-1:0] CMAX = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_cnt
);
    logic [CNT_W-1:0] cnt_q [NBINS];
    logic [CNT_W-1:0] cnt_d [NBINS];
    logic [CNT_W-1:0] rd_d, rd_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            for (int i = 0; i < NBINS; i++) cnt_d[i] = '0;
        end else if (upd_en && cnt_q[upd_idx] != CMAX) begin
            cnt_d[upd_idx] = cnt_q[upd_idx] + 1'b1;
        end
        rd_d = cnt_q[rd_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBINS; i++) cnt_q[i] <= '0;
            rd_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            rd_q  <= rd_d;
        end
    end

    assign rd_cnt = rd_q;

    // R5: a full counter stays full
    a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !clr && cnt_q[upd_idx] == CMAX) |=> cnt_q[$past(upd_idx)] == CMAX);
    // R4: an accepted update adds exactly one
    a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !clr && cnt_q[upd_idx] != CMAX) |=>
        cnt_q[$past(upd_idx)] == CNT_W'($past(cnt_q[upd_idx]) + 1'b1));
    // R6: the clear reaches both ends of the array
    a_r6_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q[0] == '0 && cnt_q[NBINS-1] == '0));
endmodule

// File: rtl/evhist_accum.sv
module evhist_accum
    import evhist_pkg::*;
#(
    parameter int X_SHIFT  = 4,
    parameter int Y_SHIFT  = 4,
    parameter int KEEP_POL = 1,
    parameter int CNT_W    = 8,
    parameter int QDEPTH   = 4,
    parameter int DROP_W   = 8,
    localparam int IDX_W   = (SENS_X_W - X_SHIFT) + (SENS_Y_W - Y_SHIFT) + KEEP_POL
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_valid,
    input  logic [SENS_X_W-1:0] ev_x,
    input  logic [SENS_Y_W-1:0] ev_y,
    input  logic                ev_pol,
    input  logic                mac_en,
    input  logic                win_start,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [CNT_W-1:0]    rd_cnt,
    output logic [DROP_W-1:0]   drop_cnt
);
    typedef struct packed {
        logic [DROP_W-1:0] drop;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [IDX_W-1:0] ev_idx, q_head, upd_idx;
    logic q_empty, q_full, q_pop, q_push, direct, upd_valid, park, lost;

    evhist_bin_map #(
        .X_SHIFT (X_SHIFT),
        .Y_SHIFT (Y_SHIFT),
        .KEEP_POL(KEEP_POL)
    ) u_map (
        .x  (ev_x),
        .y  (ev_y),
        .pol(ev_pol),
        .idx(ev_idx)
    );

    always_comb begin
        q_pop     = !mac_en && !q_empty && !win_start;
        direct    = ev_valid && !win_start && !mac_en && q_empty;
        park      = ev_valid && !win_start && (mac_en || !q_empty);
        q_push    = park && (!q_full || q_pop);
        lost      = park && q_full && !q_pop;
        upd_valid = q_pop || direct;
        upd_idx   = q_pop ? q_head : ev_idx;

        st_d = st_q;
        if (win_start) begin
            st_d.drop = '0;
        end else if (lost && st_q.drop != '1) begin
            st_d.drop = st_q.drop + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    evhist_evq #(
        .W    (IDX_W),
        .DEPTH(QDEPTH)
    ) u_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (win_start),
        .push     (q_push),
        .push_data(ev_idx),
        .pop      (q_pop),
        .head     (q_head),
        .empty    (q_empty),
        .full     (q_full)
    );

    evhist_counters #(
        .IDX_W(IDX_W),
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (win_start),
        .upd_en (upd_valid),
        .upd_idx(upd_idx),
        .rd_idx (rd_idx),
        .rd_cnt (rd_cnt)
    );

    assign drop_cnt = st_q.drop;

    // R3: no counter update reaches the array during the high phase
    a_r3_frozen_high: assert property (@(posedge clk) disable iff (!rst_n)
        mac_en |-> !upd_valid);
    // R8: outside a window start the drop count never falls
    a_r8_drop_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !win_start |=> drop_cnt >= $past(drop_cnt));
    // R6: a window start leaves the drop count at zero
    a_r6_drop_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        win_start |=> drop_cnt == '0);
endmodule

// File: tb/evhist_accum_tb.sv
module evhist_accum_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_valid = 1'b0;
    logic [6:0] ev_x = '0;
    logic [6:0] ev_y = '0;
    logic       ev_pol = 1'b0;
    logic       mac_en = 1'b0;
    logic       win_start = 1'b0;
    logic [6:0] rd_idx = '0;
    logic [7:0] rd_cnt;
    logic [7:0] drop_cnt;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    evhist_accum u_dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_x(ev_x), .ev_y(ev_y),
        .ev_pol(ev_pol), .mac_en(mac_en), .win_start(win_start), .rd_idx(rd_idx),
        .rd_cnt(rd_cnt), .drop_cnt(drop_cnt)
    );

    // {x[7], y[7], pol, bin[7], expected count of that bin after the event[8]}
    localparam int NV = 7;
    localparam logic [29:0] VEC [NV] = '{
        {7'd5,   7'd3,   1'b1, 7'd64,  8'd1},
        {7'd15,  7'd0,   1'b1, 7'd64,  8'd2},
        {7'd16,  7'd0,   1'b1, 7'd65,  8'd1},
        {7'd5,   7'd3,   1'b0, 7'd0,   8'd1},
        {7'd127, 7'd127, 1'b1, 7'd127, 8'd1},
        {7'd0,   7'd15,  1'b1, 7'd64,  8'd3},
        {7'd112, 7'd127, 1'b0, 7'd63,  8'd1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [6:0] x, input logic [6:0] y, input logic p);
        @(negedge clk);
        ev_valid = 1'b1; ev_x = x; ev_y = y; ev_pol = p;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic read_bin(input logic [6:0] idx, output int val);
        rd_idx = idx;
        @(negedge clk);
        val = rd_cnt;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R10: reset state
        check("R10 drop after reset", drop_cnt, 0);
        read_bin(7'd64, v);
        check("R10 bin after reset", v, 0);

        // R1, R2: vector table walk
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][29:23], VEC[i][22:16], VEC[i][15]);
            read_bin(VEC[i][14:8], v);
            check("R1/R2 binned count", v, int'(VEC[i][7:0]));
        end

        // R9: one-cycle read latency
        read_bin(7'd64, v);
        check("R9 read bin 64", v, 3);
        rd_idx = 7'd0;
        #1;
        check("R9 old value before edge", rd_cnt, 3);
        @(negedge clk);
        check("R9 new value after edge", rd_cnt, 1);

        // R3: events in the high phase are parked, counts frozen
        @(negedge clk); mac_en = 1'b1;
        send(7'd80, 7'd0, 1'b0);
        send(7'd80, 7'd0, 1'b0);
        read_bin(7'd5, v);
        check("R3 frozen in high phase", v, 0);
        // R7: queued events counted after the phase falls
        mac_en = 1'b0;
        idle(3);
        read_bin(7'd5, v);
        check("R7 queued events applied", v, 2);
        read_bin(7'd64, v);
        check("R4 earlier count survives MAC cycle", v, 3);

        // R8: overflow of the four-entry queue
        @(negedge clk); mac_en = 1'b1;
        for (int i = 0; i < 6; i++) send(7'd80, 7'd0, 1'b0);
        check("R8 drop count", drop_cnt, 2);
        mac_en = 1'b0;
        idle(5);
        read_bin(7'd5, v);
        check("R4/R8 cumulative after overflow", v, 6);

        // R7: pop and push in the same cycles while draining
        @(negedge clk); mac_en = 1'b1;
        for (int i = 0; i < 3; i++) send(7'd80, 7'd0, 1'b0);
        mac_en = 1'b0;
        ev_valid = 1'b1; ev_x = 7'd80; ev_y = 7'd0; ev_pol = 1'b0;
        idle(2);
        ev_valid = 1'b0;
        idle(6);
        read_bin(7'd5, v);
        check("R7 drain with arrivals", v, 11);
        check("R8 no extra drop in low phase", drop_cnt, 2);

        // R5: saturation
        @(negedge clk);
        ev_valid = 1'b1; ev_x = 7'd16; ev_y = 7'd0; ev_pol = 1'b0;
        idle(300);
        ev_valid = 1'b0;
        read_bin(7'd1, v);
        check("R5 saturated count", v, 255);

        // R6: window start with a same-cycle event
        win_start = 1'b1;
        ev_valid = 1'b1; ev_x = 7'd16; ev_y = 7'd0; ev_pol = 1'b0;
        @(negedge clk);
        win_start = 1'b0; ev_valid = 1'b0;
        read_bin(7'd1, v);
        check("R6 same-cycle event discarded", v, 0);
        read_bin(7'd5, v);
        check("R6 other bin cleared", v, 0);
        check("R6 drop count cleared", drop_cnt, 0);

        // R6: window start flushes parked events
        @(negedge clk); mac_en = 1'b1;
        send(7'd80, 7'd0, 1'b0);
        send(7'd80, 7'd0, 1'b0);
        win_start = 1'b1;
        @(negedge clk);
        win_start = 1'b0; mac_en = 1'b0;
        idle(4);
        read_bin(7'd5, v);
        check("R6 queue flushed", v, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule